// File: doc/BRIEF.md
# Multicore Boot Spin-Table Controller

This block holds the boot-release records that hold secondary processor cores in a wait loop after power-up. There is one 32-byte record per core. A record holds a 64-bit start address, a 64-bit first argument, a 32-bit processor identifier and two reserved words. A bus master, normally the boot core, reaches the records through a small synchronous register port. The port is big-endian and supports 1-, 2- and 4-byte accesses. The primary core's record and the records of cores that are not fitted are read-only.

A core stays held while bit 0 of its start address is set. Every accepted write to a record re-examines that bit. When the bit is clear, the block issues a one-cycle release pulse on that core's bit of a one-hot vector. With the pulse it presents a set of registered values:
- the entry PC, which is the start address masked to a fixed 64 MiB window;
- the window base, which is the remaining upper address bits;
- the record's argument;
- the constant window size.

At the same edge, the block overwrites the record's processor identifier with the value that the released core reports.

Top module: `spin_table_ctrl`

## Requirements
- R1: After reset, record i reads back a start address of 1, an argument of i and a processor identifier of i. All other bytes read as zero.
- R2: Bits [9:5] of an access address select the record and bits [4:0] select the byte. A 2-byte access ignores address bit 0, and a 4-byte access ignores address bits [1:0].
- R3: The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. A write stores its data big-endian, most significant lane at the lowest byte, and uses the low-order bytes of the write data. Record bytes 0-7 hold the start address, bytes 8-15 the argument, bytes 16-19 reserved, bytes 20-23 the identifier and bytes 24-31 reserved.
- R4: A read returns its bytes big-endian, right-justified and zero-extended, with the valid flag set one cycle after the request.
- R5: Size code 3 is illegal. A read with size code 3 returns the error flag with zero data. A write with size code 3 changes nothing and releases nothing.
- R6: Writes to record 0 and to any record whose bit in the present-core mask is clear are discarded.
- R7: After every accepted write that leaves bit 0 of the record's start address (bit 0 of byte 7) clear, the block sets only that core's bit of the release vector for exactly the following cycle. A further accepted write to the same record releases the core again.
- R8: During the pulse, the entry PC equals the start address ANDed with 0x3FFFFFF, the window base equals the start address with those 26 bits cleared, the argument equals the record's argument, and the window size reads 0x4000000. These values hold until the next release.
- R9: On a release, the record's identifier field takes that core's reported identifier. This value replaces any data written to the field in the same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte address into the record space |
| bus_size_i | input | 2 | Access size code |
| bus_wdata_i | input | 32 | Write data, right-justified |
| bus_rdata_o | output | 32 | Read data, right-justified |
| bus_rvalid_o | output | 1 | Read result valid |
| bus_rerr_o | output | 1 | Read had an illegal size |
| core_pid_i | input | 1024 | Reported identifier of each core, 32 bits per core |
| rel_pulse_o | output | 32 | One-hot release pulse |
| rel_pc_o | output | 64 | Entry PC within the window |
| rel_arg_o | output | 64 | First boot argument |
| rel_base_o | output | 64 | Window base address |
| rel_size_o | output | 64 | Window size |

## Verification
The assertions assume that at most one access arrives per cycle and that the core identifier inputs stay stable. With those inputs, a pulse can only follow a write in the previous cycle, and at most one pulse bit can be set. The bench holds the identifier bus constant and issues a single access per clock. It mixes directed cases with seeded random accesses that favour byte 7 and the start-address words, so that holds and releases alternate often. The random accesses also include illegal sizes and protected records.

// File: rtl/spin_pkg.sv
package spin_pkg;

    localparam int REC_BYTES = 32;
    localparam int REC_BITS  = REC_BYTES * 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // Field order equals byte order: the first field sits at byte 0 (big-endian)
    typedef struct packed {
        logic [63:0] start;
        logic [63:0] arg;
        logic [31:0] rsv_a;
        logic [31:0] pid;
        logic [63:0] rsv_b;
    } boot_rec_t;

    function automatic int size_lanes(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [4:0] align_off(logic [4:0] off, acc_size_e sz);
        case (sz)
            SZ_HALF: return {off[4:1], 1'b0};
            SZ_WORD: return {off[4:2], 2'b00};
            default: return off;
        endcase
    endfunction

    // Byte k of a big-endian record lives at little-endian slot 31-k, i.e. ~k
    function automatic logic [7:0] rec_byte(logic [REC_BITS-1:0] v, logic [4:0] k);
        return v[{~k, 3'b000} +: 8];
    endfunction

    function automatic boot_rec_t rec_merge(boot_rec_t r, logic [4:0] off,
                                            acc_size_e sz, logic [31:0] wd);
        logic [REC_BITS-1:0] v;
        logic [31:0]         lj;
        logic [4:0]          base;
        logic [4:0]          k;
        int                  n;
        v    = r;
        n    = size_lanes(sz);
        base = align_off(off, sz);
        lj   = (n == 0) ? 32'd0 : (wd << (8 * (4 - n)));
        for (int l = 0; l < 4; l++) begin
            if (l < n) begin
                k = base + 5'(l);
                v[{~k, 3'b000} +: 8] = lj[31 - 8*l -: 8];
            end
        end
        return boot_rec_t'(v);
    endfunction

    function automatic logic [31:0] rec_extract(boot_rec_t r, logic [4:0] off,
                                                acc_size_e sz);
        logic [31:0] lj;
        logic [4:0]  base;
        int          n;
        lj   = '0;
        n    = size_lanes(sz);
        base = align_off(off, sz);
        for (int l = 0; l < 4; l++) begin
            if (l < n) lj[31 - 8*l -: 8] = rec_byte(r, base + 5'(l));
        end
        return (n == 0) ? 32'd0 : (lj >> (8 * (4 - n)));
    endfunction

endpackage

// File: rtl/spin_rec_slot.sv
module spin_rec_slot
    import spin_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      rel_en,
    input  boot_rec_t wr_rec,
    input  logic [31:0] pid_in,
    output boot_rec_t rec_q
);

    boot_rec_t reset_rec;

    always_comb begin
        reset_rec       = '0;
        reset_rec.start = 64'd1;
        reset_rec.arg   = 64'(IDX);
        reset_rec.pid   = 32'(IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= reset_rec;
        end else if (wr_en) begin
            rec_q <= wr_rec;
            if (rel_en) rec_q.pid <= pid_in;
        end
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // A record never changes without a write strobe for it
    assert_slot_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && !wr_en) |=> $stable(rec_q));

    // A release loads the reported identifier into the record
    assert_pid_load_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && wr_en && rel_en) |=> (rec_q.pid == $past(pid_in)));

endmodule

// File: rtl/spin_rd_port.sv
module spin_rd_port
    import spin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_fire,
    input  acc_size_e   rd_size,
    input  logic [4:0]  rd_off,
    input  logic        rd_in_range,
    input  boot_rec_t   rd_rec,
    output logic [31:0] rdata_q,
    output logic        rvalid_q,
    output logic        rerr_q
);

    logic        bad;
    logic [31:0] word;

    always_comb begin
        bad  = (rd_size == SZ_BAD);
        word = (bad || !rd_in_range) ? 32'd0 : rec_extract(rd_rec, rd_off, rd_size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            rerr_q   <= 1'b0;
        end else begin
            rvalid_q <= rd_fire;
            rerr_q   <= rd_fire && bad;
            rdata_q  <= rd_fire ? word : 32'd0;
        end
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rerr_q |-> (rvalid_q && rdata_q == 32'd0));

    assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
        armed |-> (rvalid_q == $past(rd_fire)));

    assert_byte_width_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(rd_fire) && $past(rd_size) == SZ_BYTE) |-> (rdata_q[31:8] == 24'd0));

endmodule

// File: rtl/spin_release_unit.sv
module spin_release_unit
    import spin_pkg::*;
#(
    parameter int NUM_CORES = 32,
    parameter int MAP_LOG2  = 26,
    parameter int IDX_W     = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit,
    input  logic [IDX_W-1:0]     hit_idx,
    input  logic [63:0]          start_addr,
    input  logic [63:0]          start_arg,
    output logic [NUM_CORES-1:0] pulse_q,
    output logic [63:0]          pc_q,
    output logic [63:0]          base_q,
    output logic [63:0]          arg_q
);

    localparam logic [63:0] WIN_MASK = (64'd1 << MAP_LOG2) - 64'd1;

    logic [NUM_CORES-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (hit && hit_idx == IDX_W'(i)) sel[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
            pc_q    <= '0;
            base_q  <= '0;
            arg_q   <= '0;
        end else begin
            pulse_q <= sel;
            if (hit) begin
                pc_q   <= start_addr & WIN_MASK;
                base_q <= start_addr & ~WIN_MASK;
                arg_q  <= start_arg;
            end
        end
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_pulse_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_q));

    assert_split_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse_q != '0) |-> ((pc_q & base_q) == 64'd0 && pc_q[0] == 1'b0
                              && (pc_q >> MAP_LOG2) == 64'd0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && pulse_q == '0) |-> ($stable(pc_q) && $stable(base_q) && $stable(arg_q)));

endmodule

// File: rtl/spin_table_ctrl.sv
module spin_table_ctrl
    import spin_pkg::*;
#(
    parameter int          NUM_CORES    = 32,
    parameter logic [31:0] PRESENT_MASK = 32'hFFFF_FFFF,
    parameter int          MAP_LOG2     = 26,
    parameter int          IDX_W        = $clog2(NUM_CORES),
    parameter int          ADDR_W       = IDX_W + 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_req_i,
    input  logic                    bus_we_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [1:0]              bus_size_i,
    input  logic [31:0]             bus_wdata_i,
    output logic [31:0]             bus_rdata_o,
    output logic                    bus_rvalid_o,
    output logic                    bus_rerr_o,
    input  logic [NUM_CORES*32-1:0] core_pid_i,
    output logic [NUM_CORES-1:0]    rel_pulse_o,
    output logic [63:0]             rel_pc_o,
    output logic [63:0]             rel_arg_o,
    output logic [63:0]             rel_base_o,
    output logic [63:0]             rel_size_o
);

    localparam logic [NUM_CORES-1:0] WRITABLE = NUM_CORES'(PRESENT_MASK) & ~NUM_CORES'(1);

    acc_size_e       acc_sz;
    logic [IDX_W-1:0] idx;
    logic [4:0]      off;
    logic            in_range;
    boot_rec_t       recs_q [NUM_CORES];
    boot_rec_t       cur_rec;
    boot_rec_t       merged;
    logic [31:0]     cur_pid;
    logic            wr_ok;
    logic            rel_hit;
    logic [NUM_CORES-1:0] wr_en;
    logic [NUM_CORES-1:0] rel_en;

    always_comb begin
        acc_sz   = acc_size_e'(bus_size_i);
        idx      = bus_addr_i[ADDR_W-1:5];
        off      = bus_addr_i[4:0];
        in_range = (32'(idx) < NUM_CORES);
        cur_rec  = '0;
        cur_pid  = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (idx == IDX_W'(i)) begin
                cur_rec = recs_q[i];
                cur_pid = core_pid_i[i*32 +: 32];
            end
        end
        merged  = rec_merge(cur_rec, off, acc_sz, bus_wdata_i);
        wr_ok   = bus_req_i && bus_we_i && acc_sz != SZ_BAD && in_range && WRITABLE[idx];
        rel_hit = wr_ok && !merged.start[0];
        for (int i = 0; i < NUM_CORES; i++) begin
            wr_en[i]  = wr_ok   && idx == IDX_W'(i);
            rel_en[i] = rel_hit && idx == IDX_W'(i);
        end
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        spin_rec_slot #(.IDX(g)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en[g]),
            .rel_en (rel_en[g]),
            .wr_rec (merged),
            .pid_in (core_pid_i[g*32 +: 32]),
            .rec_q  (recs_q[g])
        );
    end

    spin_rd_port u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_fire     (bus_req_i && !bus_we_i),
        .rd_size     (acc_sz),
        .rd_off      (off),
        .rd_in_range (in_range),
        .rd_rec      (cur_rec),
        .rdata_q     (bus_rdata_o),
        .rvalid_q    (bus_rvalid_o),
        .rerr_q      (bus_rerr_o)
    );

    spin_release_unit #(
        .NUM_CORES (NUM_CORES),
        .MAP_LOG2  (MAP_LOG2),
        .IDX_W     (IDX_W)
    ) u_rel (
        .clk        (clk),
        .rst        (rst),
        .hit        (rel_hit),
        .hit_idx    (idx),
        .start_addr (merged.start),
        .start_arg  (merged.arg),
        .pulse_q    (rel_pulse_o),
        .pc_q       (rel_pc_o),
        .base_q     (rel_base_o),
        .arg_q      (rel_arg_o)
    );

    assign rel_size_o = 64'd1 << MAP_LOG2;

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // The primary core's record is never altered by the bus
    assert_primary_locked_R6: assert property (@(posedge clk) disable iff (rst)
        armed |-> $stable(recs_q[0]));

    // A pulse is always the consequence of a write in the previous cycle
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && rel_pulse_o != '0) |-> $past(bus_req_i && bus_we_i));

    // An illegal-size write never produces a pulse
    assert_bad_write_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req_i && bus_we_i && acc_sz == SZ_BAD) |=> (rel_pulse_o == '0));

endmodule

// File: tb/sim_spin_table_ctrl.sv
module sim_spin_table_ctrl;

    localparam int          N    = 32;
    localparam logic [31:0] PRES = 32'hF3FF_5F7F;

    logic        clk = 1'b0;
    logic        rst;
    logic        req, we;
    logic [9:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid, rerr;
    logic [N*32-1:0] pid_bus;
    logic [N-1:0] pulse;
    logic [63:0] pc, arg, base, msize;

    always #4 clk = ~clk;

    spin_table_ctrl #(.NUM_CORES(N), .PRESENT_MASK(PRES)) u0 (
        .clk(clk), .rst(rst), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
        .bus_size_i(size), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bus_rvalid_o(rvalid), .bus_rerr_o(rerr), .core_pid_i(pid_bus),
        .rel_pulse_o(pulse), .rel_pc_o(pc), .rel_arg_o(arg),
        .rel_base_o(base), .rel_size_o(msize)
    );

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    // Bench model: byte arrays, byte 0 of each record is most significant
    logic [7:0]  mb [N][32];
    logic [63:0] exp_pc, exp_base, exp_arg;

    function automatic logic [31:0] pid_of(int i);
        return 32'hA500_0000 + 32'(i * 7);
    endfunction

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
    endfunction

    function automatic logic [63:0] m_field(int r, int b);
        logic [63:0] v = '0;
        for (int j = 0; j < 8; j++) v = {v[55:0], mb[r][b + j]};
        return v;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < N; r++) begin
            for (int b = 0; b < 32; b++) mb[r][b] = 8'h00;
            mb[r][7]  = 8'h01;
            mb[r][15] = 8'(r);
            mb[r][23] = 8'(r);
        end
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int r, int off, logic [1:0] s, logic [31:0] d);
        int n = nbytes(s);
        int a0;
        logic [N-1:0] exp_pulse = '0;
        @(negedge clk);
        req = 1; we = 1; addr = 10'(r * 32 + off); size = s; wdata = d;
        a0 = (n == 2) ? (off & ~1) : (n == 4) ? (off & ~3) : off;
        if (n != 0 && PRES[r] && r != 0) begin
            for (int j = 0; j < n; j++) mb[r][a0 + j] = d[8*(n-1-j) +: 8];
            if (mb[r][7][0] == 1'b0) begin
                exp_pulse[r] = 1'b1;
                exp_pc   = m_field(r, 0) & 64'h3FF_FFFF;
                exp_base = m_field(r, 0) & ~64'h3FF_FFFF;
                exp_arg  = m_field(r, 8);
                for (int j = 0; j < 4; j++) mb[r][20 + j] = pid_of(r)[8*(3-j) +: 8];
            end
        end
        @(negedge clk);
        req = 0; we = 0;
        check("R7 pulse vector", 64'(pulse), 64'(exp_pulse));
        if (exp_pulse != '0) begin
            check("R8 entry pc", pc, exp_pc);
            check("R8 window base", base, exp_base);
            check("R8 argument", arg, exp_arg);
            check("R8 window size", msize, 64'h400_0000);
        end
    endtask

    task automatic rd(int r, int off, logic [1:0] s, string tag);
        int n = nbytes(s);
        int a0;
        logic [31:0] e = '0;
        @(negedge clk);
        req = 1; we = 0; addr = 10'(r * 32 + off); size = s;
        a0 = (n == 2) ? (off & ~1) : (n == 4) ? (off & ~3) : off;
        for (int j = 0; j < n; j++) e = {e[23:0], mb[r][a0 + j]};
        @(negedge clk);
        req = 0;
        check({tag, " rvalid"}, 64'(rvalid), 64'd1);
        check({tag, " rerr"}, 64'(rerr), (n == 0) ? 64'd1 : 64'd0);
        check({tag, " rdata"}, 64'(rdata), 64'(e));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int seed = 32'h5EED;
        void'($urandom(seed));
        for (int i = 0; i < N; i++) pid_bus[i*32 +: 32] = pid_of(i);
        req = 0; we = 0; addr = '0; size = '0; wdata = '0;
        rst = 1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check("R7 pulse idle after reset", 64'(pulse), 64'd0);
        check("R4 rvalid idle after reset", 64'(rvalid), 64'd0);

        // R1 reset contents
        for (int r = 0; r < N; r += 5) begin
            rd(r, 4,  2'd2, "R1 start low");
            rd(r, 12, 2'd2, "R1 arg low");
            rd(r, 20, 2'd2, "R1 pid");
            rd(r, 24, 2'd2, "R1 reserved");
        end
        // R2/R3 alignment and big-endian lane placement
        wr(2, 9, 2'd2, 32'h1122_3344);   // aligns down to byte 8
        rd(2, 8,  2'd2, "R2 word aligned down");
        rd(2, 9,  2'd0, "R3 single byte");
        wr(2, 17, 2'd1, 32'hBEEF);       // aligns down to byte 16
        rd(2, 16, 2'd2, "R3 half merge");
        rd(2, 19, 2'd1, "R2 half aligned down");
        // R5 illegal size
        rd(3, 0, 2'd3, "R5 bad read");
        wr(3, 4, 2'd3, 32'h0000_0000);
        rd(3, 4, 2'd2, "R5 bad write ignored");
        // R6 protected records
        wr(0, 4, 2'd2, 32'h0000_1000);
        rd(0, 4, 2'd2, "R6 primary protected");
        wr(7, 4, 2'd2, 32'h0000_1000);   // core 7 absent
        rd(7, 4, 2'd2, "R6 absent protected");
        // R7/R8/R9 release of core 1
        wr(1, 0, 2'd2, 32'h0000_0002);
        wr(1, 4, 2'd2, 32'h0123_4560);
        @(negedge clk);
        check("R7 pulse lasts one cycle", 64'(pulse), 64'd0);
        check("R8 pc held", pc, 64'h0123_4560);
        rd(1, 20, 2'd2, "R9 pid replaced");
        wr(1, 20, 2'd2, 32'h0BAD_0BAD);  // re-release; pid replaced again
        rd(1, 20, 2'd2, "R9 pid wins over write");
        wr(1, 7, 2'd0, 32'h0000_0001);   // hold again
        wr(1, 12, 2'd2, 32'h55);
        rd(1, 12, 2'd2, "R7 held core arg write");

        // Random mix
        for (int it = 0; it < 3000; it++) begin
            int r = int'($urandom_range(0, N - 1));
            int k = int'($urandom_range(0, 9));
            logic [1:0] s = 2'($urandom_range(0, 3));
            int off = int'($urandom_range(0, 31));
            logic [31:0] d = $urandom();
            if (k < 3)      wr(r, 7, 2'd0, d);
            else if (k < 5) wr(r, off & 28, 2'd2, d);
            else if (k < 7) wr(r, off, s, d);
            else            rd(r, off, s, "R4 random read");
        end
        summary();
    end

endmodule